// File: doc/BRIEF.md
# Rollover Sample FIFO with Almost-Full Interrupt

This block buffers 24-bit samples between an acquisition engine and a host. It holds up to 32 samples in a ring of storage addressed by a write pointer and a read pointer. A running count of unread samples is kept next to the pointers. The read port is show-ahead: the oldest unread sample is always visible on the read data output, and asserting a read consumes it.

When the ring is full, a configuration bit selects one of two policies. Under wrap, a new sample overwrites the oldest one and the read position moves forward with it. Under hold, new samples are discarded and counted until the host reads or rewrites a pointer.

The almost-full threshold counts the empty slots that remain, not the fill level. The interrupt latches on entry into the threshold condition. It stays set until the host clears it or the block is put into shutdown. The host may also load either pointer directly, and this re-derives the count.

Top module: `samp_ring_fifo`

## Requirements
- R1: After reset, the unread count is 0, the interrupt flag is 0 and the overflow counter is 0.
- R2: Samples leave in the order they were written. `rd_data` shows the oldest unread sample whenever the count is non-zero, and a read moves it to the next one.
- R3: The count rises by one for each accepted write, falls by one for each accepted read, and never exceeds 32. A read while the count is 0 is ignored and leaves the count at 0.
- R4: With `roll_en`=1 and the count at 32, a write without a read stores the new sample as the newest entry and discards the oldest one. The count stays at 32, and `rd_data` moves on to the next-oldest sample.
- R5: With `roll_en`=0 and the count at 32, a write without a read is dropped and leaves both the contents and the count unchanged. Each such drop adds one to `ovf_cnt`, which saturates at 31.
- R6: A read and a write in the same cycle at count 32 are both performed under either policy. The count stays at 32 and `ovf_cnt` does not change.
- R7: The threshold condition is count >= 32 − `afull_thr`. Threshold 0 therefore needs 32 unread samples and threshold 15 needs 17. `afull_irq` goes to 1 on the clock edge after the cycle in which the condition first becomes true.
- R8: `afull_irq` stays at 1 until `irq_clr` is asserted. After a clear, it is set again only when the condition has first been false and then becomes true again.
- R9: `shutdown` forces `afull_irq` to 0 at the next edge and keeps it at 0 while it stays asserted. This overrides a new set.
- R10: `wptr_ld` and `rptr_ld` load `ptr_val` into the write or read pointer. Either may be asserted alone or both together. The count becomes (write pointer − read pointer) mod 32, so equal pointers mean empty. Reads and writes in a load cycle are ignored. A load releases a ring that is full under hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request from the acquisition side |
| wr_data | input | 24 | Sample to write |
| rd_en | input | 1 | Read request from the host |
| rd_data | output | 24 | Oldest unread sample (show-ahead) |
| roll_en | input | 1 | 1: wrap and overwrite when full; 0: hold and drop |
| afull_thr | input | 4 | Empty-slot count at which the interrupt fires |
| wptr_ld | input | 1 | Load the write pointer from `ptr_val` |
| rptr_ld | input | 1 | Load the read pointer from `ptr_val` |
| ptr_val | input | 5 | Pointer value for a load |
| irq_clr | input | 1 | Host clear of the interrupt flag |
| shutdown | input | 1 | Forces the interrupt flag to 0 |
| count | output | 6 | Number of unread samples, 0 to 32 |
| afull_irq | output | 1 | Latched almost-full interrupt |
| ovf_cnt | output | 5 | Saturating count of dropped writes |

## Verification
The ring is first driven with short bursts of writes and reads, including reads of an empty ring, which separate ordering errors from count errors. It is then filled to 32 and written further under each policy, with and without a simultaneous read. This tells overwrite apart from drop, and a wrongly advanced read pointer from a wrongly moved write pointer. Pointer loads are applied singly and together, with the ring frozen and with it empty, which exposes wrong wrap arithmetic in the count. The interrupt is exercised at thresholds 4 and 0, across clears while the condition still holds and under shutdown, to separate edge-set behaviour from level-set behaviour.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;

    typedef enum logic {
        POL_HOLD = 1'b0,
        POL_WRAP = 1'b1
    } full_policy_e;

    // One cycle's decided actions on the ring
    typedef struct packed {
        logic load;   // pointer load, ring traffic suppressed
        logic wr;     // sample stored at write pointer
        logic rd;     // oldest sample consumed by host
        logic bump;   // read pointer pushed by a wrapping overwrite
        logic drop;   // write discarded while full under hold
    } ring_op_t;

    function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] lim);
        return (v >= lim) ? lim : v + 8'd1;
    endfunction

endpackage

// File: rtl/sfifo_ctrl.sv
`timescale 1ns/1ps
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int OVF_W = 5,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          roll_en,
    input  logic          wptr_ld,
    input  logic          rptr_ld,
    input  logic [AW-1:0] ptr_val,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output ring_op_t      op,
    output logic [OVF_W-1:0] ovf_cnt
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    full_policy_e pol;
    logic full, empty, blocked;
    logic [AW-1:0] nw, nr;

    always_comb begin
        pol     = roll_en ? POL_WRAP : POL_HOLD;
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        op.load = wptr_ld | rptr_ld;
        op.rd   = !op.load && rd_en && !empty;
        blocked = !op.load && wr_en && full && !op.rd;
        op.bump = blocked && (pol == POL_WRAP);
        op.drop = blocked && (pol == POL_HOLD);
        op.wr   = !op.load && wr_en && !op.drop;
        nw      = wptr_ld ? ptr_val : wptr;
        nr      = rptr_ld ? ptr_val : rptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            ovf_cnt <= '0;
        end else begin
            if (op.load) begin
                wptr  <= nw;
                rptr  <= nr;
                count <= CW'(AW'(nw - nr));
            end else begin
                wptr  <= wptr + AW'(op.wr);
                rptr  <= rptr + AW'(op.rd | op.bump);
                count <= count + CW'(op.wr) - CW'(op.rd) - CW'(op.bump);
            end
            if (op.drop && ovf_cnt != OVF_MAX)
                ovf_cnt <= ovf_cnt + OVF_W'(1);
        end
    end

endmodule

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
module sfifo_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];

endmodule

// File: rtl/sfifo_irq.sv
`timescale 1ns/1ps
module sfifo_irq #(
    parameter int DEPTH = 32,
    parameter int THR_W = 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    count,
    input  logic [THR_W-1:0] thr,
    input  logic             clr,
    input  logic             shutdown,
    output logic             irq
);
    logic at_level, at_level_q;

    assign at_level = (count >= (CW'(DEPTH) - CW'(thr)));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            at_level_q <= 1'b0;
        end else begin
            at_level_q <= at_level;
            if (shutdown)
                irq <= 1'b0;
            else if (at_level && !at_level_q)
                irq <= 1'b1;
            else if (clr)
                irq <= 1'b0;
        end
    end

endmodule

// File: rtl/samp_ring_fifo.sv
`timescale 1ns/1ps
module samp_ring_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 24,
    parameter int THR_W  = 4,
    parameter int OVF_W  = 5,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              roll_en,
    input  logic [THR_W-1:0]  afull_thr,
    input  logic              wptr_ld,
    input  logic              rptr_ld,
    input  logic [AW-1:0]     ptr_val,
    input  logic              irq_clr,
    input  logic              shutdown,
    output logic [CW-1:0]     count,
    output logic              afull_irq,
    output logic [OVF_W-1:0]  ovf_cnt
);
    logic [AW-1:0] wptr, rptr;
    ring_op_t      op;

    sfifo_ctrl #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .roll_en(roll_en),
        .wptr_ld(wptr_ld), .rptr_ld(rptr_ld), .ptr_val(ptr_val),
        .wptr(wptr), .rptr(rptr), .count(count), .op(op), .ovf_cnt(ovf_cnt)
    );

    sfifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(op.wr), .waddr(wptr), .wdata(wr_data),
        .raddr(rptr), .rdata(rd_data)
    );

    sfifo_irq #(.DEPTH(DEPTH), .THR_W(THR_W)) u_irq (
        .clk(clk), .rst(rst), .count(count), .thr(afull_thr),
        .clr(irq_clr), .shutdown(shutdown), .irq(afull_irq)
    );

endmodule

// File: rtl/sfifo_chk.sv
`timescale 1ns/1ps
module sfifo_chk #(
    parameter int DEPTH = 32,
    parameter int THR_W = 4,
    parameter int OVF_W = 5,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             roll_en,
    input logic [THR_W-1:0] afull_thr,
    input logic             wptr_ld,
    input logic             rptr_ld,
    input logic             shutdown,
    input logic [CW-1:0]    count,
    input logic             afull_irq,
    input logic [OVF_W-1:0] ovf_cnt
);
    localparam logic [CW-1:0]    FULL_CNT = CW'(DEPTH);
    localparam logic [OVF_W-1:0] OVF_MAX  = '1;

    logic no_ld;
    assign no_ld = !wptr_ld && !rptr_ld;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
        (no_ld && rd_en && !wr_en && count == '0) |=> (count == '0));

    assert_wrap_stays_full_R4: assert property (@(posedge clk) disable iff (rst)
        (no_ld && wr_en && roll_en && count == FULL_CNT) |=> (count == FULL_CNT));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (no_ld && wr_en && !rd_en && !roll_en && count == FULL_CNT) |=>
        (ovf_cnt == (($past(ovf_cnt) == OVF_MAX) ? OVF_MAX : $past(ovf_cnt) + OVF_W'(1))));

    assert_rw_full_R6: assert property (@(posedge clk) disable iff (rst)
        (no_ld && wr_en && rd_en && count == FULL_CNT) |=>
        (count == FULL_CNT && $stable(ovf_cnt)));

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(afull_irq) |-> ($past(count) >= FULL_CNT - CW'($past(afull_thr))));

    assert_shutdown_R9: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> !afull_irq);

endmodule

bind samp_ring_fifo sfifo_chk #(.DEPTH(DEPTH), .THR_W(THR_W), .OVF_W(OVF_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .roll_en(roll_en),
    .afull_thr(afull_thr), .wptr_ld(wptr_ld), .rptr_ld(rptr_ld),
    .shutdown(shutdown), .count(count), .afull_irq(afull_irq), .ovf_cnt(ovf_cnt)
);

// File: tb/samp_ring_fifo_tb.sv
`timescale 1ns/1ps
module samp_ring_fifo_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, rd_en = 0, roll_en = 0, wptr_ld = 0, rptr_ld = 0;
    logic        irq_clr = 0, shutdown = 0;
    logic [23:0] wr_data = '0;
    logic [3:0]  afull_thr = 4'd4;
    logic [4:0]  ptr_val = '0;
    logic [23:0] rd_data;
    logic [5:0]  count;
    logic        afull_irq;
    logic [4:0]  ovf_cnt;

    int checks = 0, errors = 0;
    int mw [32];
    int wp = 0, rp = 0, cnt = 0, ovf = 0, seq = 0;
    bit irq = 0, cq = 0;

    always #2.5 clk = ~clk;

    samp_ring_fifo u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .roll_en(roll_en), .afull_thr(afull_thr),
        .wptr_ld(wptr_ld), .rptr_ld(rptr_ld), .ptr_val(ptr_val),
        .irq_clr(irq_clr), .shutdown(shutdown), .count(count),
        .afull_irq(afull_irq), .ovf_cnt(ovf_cnt)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "count", int'(count), cnt);
        check(tag, "afull_irq", int'(afull_irq), int'(irq));
        check(tag, "ovf_cnt", int'(ovf_cnt), ovf);
        if (cnt > 0) check(tag, "rd_data", int'(rd_data), mw[rp]);
    endtask

    // One clock: drive inputs, advance the model, sample at the falling edge
    task automatic step(input bit w, input bit r, input bit wl, input bit rl,
                        input int pv, input bit clr, input bit sd, input string tag);
        bit ld, full, rdok, wrok, bump, drop, cond;
        int d;
        d = 24'h5A0000 + seq;
        seq++;
        wr_en = w; wr_data = d[23:0]; rd_en = r; wptr_ld = wl; rptr_ld = rl;
        ptr_val = pv[4:0]; irq_clr = clr; shutdown = sd;
        cond = (cnt >= 32 - int'(afull_thr));
        if (sd) irq = 0;
        else if (cond && !cq) irq = 1;
        else if (clr) irq = 0;
        cq = cond;
        ld = wl || rl;
        full = (cnt == 32);
        if (ld) begin
            if (wl) wp = pv;
            if (rl) rp = pv;
            cnt = (wp - rp + 32) % 32;
        end else begin
            rdok = r && cnt > 0;
            bump = w && full && !rdok && roll_en;
            drop = w && full && !rdok && !roll_en;
            wrok = w && !drop;
            if (wrok) begin mw[wp] = d; wp = (wp + 1) % 32; end
            if (rdok || bump) rp = (rp + 1) % 32;
            cnt = cnt + int'(wrok) - int'(rdok) - int'(bump);
            if (drop && ovf < 31) ovf++;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input string tag);  step(1, 0, 0, 0, 0, 0, 0, tag); endtask
    task automatic rd(input string tag);  step(0, 1, 0, 0, 0, 0, 0, tag); endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R1", "count", int'(count), 0);
        check("R1", "afull_irq", int'(afull_irq), 0);
        check("R1", "ovf_cnt", int'(ovf_cnt), 0);
        for (int i = 0; i < 5; i++) wr("R2");
        for (int i = 0; i < 3; i++) rd("R2");
        for (int i = 0; i < 3; i++) rd("R3");
        for (int i = 0; i < 32; i++) wr("R7");
        step(0, 0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        for (int i = 0; i < 3; i++) wr("R5");
        step(1, 1, 0, 0, 0, 0, 0, "R6");
        roll_en = 1'b1;
        step(1, 1, 0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 3; i++) wr("R4");
        rd("R4");
        roll_en = 1'b0;
        wr("R5");
        wr("R5");
        step(0, 0, 0, 1, 7, 0, 0, "R10");
        wr("R10");
        step(0, 0, 1, 0, 20, 0, 0, "R10");
        rd("R10");
        step(0, 0, 1, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 1, 0, "R8");
        for (int i = 0; i < 60; i++) wr("R5");
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        step(1, 1, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        afull_thr = 4'd0;
        step(0, 0, 1, 1, 3, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 1, 0, "R7");
        for (int i = 0; i < 33; i++) wr("R7");
        afull_thr = 4'd15;
        for (int i = 0; i < 16; i++) rd("R7");
        step(0, 0, 0, 0, 0, 1, 0, "R8");
        wr("R7");
        rd("R7");
        rd("R7");
        wr("R7");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule